// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block converts pointer events (a signed horizontal step, a signed vertical step and three button levels) into the five-byte report used by a three-button serial mouse. The bytes go into a small circular byte queue. A serial receive channel drains that queue one byte at a time.

An event is offered with a one-cycle valid strobe. The encoder takes it when it is idle, then writes one byte per clock into the queue. It holds `busy` high until the last of the five bytes has been written. The host read path sees the oldest queued byte together with an availability flag. It pulses `byte_taken` to move on to the next byte.

The report byte order is:

1. A header byte that carries the buttons, active low.
2. The horizontal step, saturated.
3. The vertical step, with its sign flipped and then saturated.
4. A zero byte.
5. A zero byte.

Top module: `mouse_pkt_top`

## Requirements
- R1: After a synchronous reset, `rx_avail` is 0, `rx_byte` is 0x00 and `busy` is 0.
- R2: An event is accepted when `evt_valid` is high while `busy` is low. `busy` is high for exactly five clock cycles after the accepting edge. In those five cycles the queue receives header, X, Y, 0x00, 0x00, one byte per clock, in that order.
- R3: The header is 0x87 with bit 2 cleared while the left button is held, bit 1 cleared while the middle button is held, and bit 0 cleared while the right button is held.
- R4: The X byte is `evt_dx`, a 10-bit two's complement value, limited to the range -127..+127 and emitted as 8-bit two's complement. So 300 gives 0x7F and -512 gives 0x81.
- R5: The Y byte is the negation of `evt_dy`, limited to -127..+127. So dy = 3 gives 0xFD and dy = -512 gives 0x7F.
- R6: An `evt_valid` pulse that arrives while `busy` is high is ignored and adds no bytes.
- R7: The queue holds DEPTH bytes (default 16). A byte written while the queue already holds DEPTH bytes is dropped, even when a pop happens in the same cycle.
- R8: `rx_avail` is high exactly when the queue is non-empty, and `rx_byte` shows the oldest queued byte. A byte written into an empty queue is visible from the cycle after it is written. `rx_byte` does not change while no pop happens and the queue is non-empty.
- R9: A `byte_taken` pulse removes the oldest byte and presents the next one. A pulse on an empty queue has no effect, and `rx_byte` reads 0x00 while the queue is empty.
- R10: The read and write positions wrap to the start of storage, so byte order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Pointer event strobe |
| evt_dx | input | 10 | Horizontal step, two's complement |
| evt_dy | input | 10 | Vertical step, two's complement |
| btn_left | input | 1 | Left button held |
| btn_mid | input | 1 | Middle button held |
| btn_right | input | 1 | Right button held |
| byte_taken | input | 1 | Host has consumed the presented byte |
| busy | output | 1 | Encoder is still writing the current report |
| rx_byte | output | 8 | Oldest queued byte, 0x00 when empty |
| rx_avail | output | 1 | Queue holds at least one byte |

## Verification
The checker takes for granted that `byte_taken` is a single-cycle pulse issued by a reader that looks at `rx_avail`. The bench nevertheless sends pulses on an empty queue on purpose, and the checker treats those as having no effect. It also takes for granted that a new event is offered only as a strobe. The bench respects this by driving `evt_valid` for one cycle after it sees `busy` low, except in the scenario where it deliberately strikes while `busy` is high. The bench never pops while a report is being written, so its own queue model can drop bytes at the moment they are written without having to follow simultaneous pop and write ordering.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;

  localparam logic [7:0] HDR_IDLE = 8'h87;
  localparam int unsigned PKT_BYTES = 5;

  // limit a signed value to +/-127 and return its 8-bit two's complement form
  function automatic logic [7:0] limit127(input logic signed [15:0] v);
    if (v > 16'sd127)
      return 8'h7F;
    else if (v < -16'sd127)
      return 8'h81;
    else
      return v[7:0];
  endfunction

endpackage

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int MW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  input  logic [MW-1:0] evt_dx,
  input  logic [MW-1:0] evt_dy,
  input  logic          btn_l,
  input  logic          btn_m,
  input  logic          btn_r,
  output logic          busy,
  output logic          push_vld,
  output logic [7:0]    push_dat
);

  localparam int SHW = 8 * PKT_BYTES;
  localparam int CNTW = $clog2(PKT_BYTES);

  logic                   active;
  logic [CNTW-1:0]        sent;
  logic [SHW-1:0]         shreg;
  logic signed [15:0]     x_ext, y_ext, y_neg;
  logic [7:0]             hdr, xb, yb;

  always_comb begin
    x_ext = {{(16-MW){evt_dx[MW-1]}}, evt_dx};
    y_ext = {{(16-MW){evt_dy[MW-1]}}, evt_dy};
    y_neg = -y_ext;
    hdr   = HDR_IDLE & ~{5'b0, btn_l, btn_m, btn_r};
    xb    = limit127(x_ext);
    yb    = limit127(y_neg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sent   <= '0;
      shreg  <= '0;
    end else if (!active) begin
      if (evt_valid) begin
        active <= 1'b1;
        sent   <= '0;
        shreg  <= {16'h0000, yb, xb, hdr};
      end
    end else begin
      shreg <= {8'h00, shreg[SHW-1:8]};
      if (sent == CNTW'(PKT_BYTES - 1)) begin
        active <= 1'b0;
        sent   <= '0;
      end else begin
        sent <= sent + 1'b1;
      end
    end
  end

  assign busy     = active;
  assign push_vld = active;
  assign push_dat = shreg[7:0];

endmodule

// File: rtl/mouse_byte_fifo.sv
module mouse_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [7:0]                 push_dat,
  input  logic                       pop,
  output logic [7:0]                 head,
  output logic                       avail,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_inc, rptr_inc;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_ok, rd_ok;
  logic [7:0]    head_n;

  generate
    if (POW2) begin : g_wrap_natural
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_inc = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_comb begin
    wr_ok = push && (cnt != CW'(DEPTH));
    rd_ok = pop && (cnt != '0);
    cnt_n = cnt + CW'(wr_ok) - CW'(rd_ok);
    if (cnt_n == '0)
      head_n = 8'h00;
    else if ((cnt == '0) || (rd_ok && cnt == CW'(1)))
      head_n = push_dat;
    else if (rd_ok)
      head_n = mem[rptr_inc];
    else
      head_n = head;
  end

  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[wptr] <= push_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      head  <= 8'h00;
      avail <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr_inc;
      if (rd_ok) rptr <= rptr_inc;
      cnt   <= cnt_n;
      head  <= head_n;
      avail <= (cnt_n != '0);
    end
  end

  assign fill = cnt;

endmodule

// File: rtl/mouse_pkt_top.sv
module mouse_pkt_top #(
  parameter int MW    = 10,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  input  logic [MW-1:0] evt_dx,
  input  logic [MW-1:0] evt_dy,
  input  logic          btn_left,
  input  logic          btn_mid,
  input  logic          btn_right,
  input  logic          byte_taken,
  output logic          busy,
  output logic [7:0]    rx_byte,
  output logic          rx_avail
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          push_vld;
  logic [7:0]    push_dat;
  logic [CW-1:0] q_fill;

  mouse_pkt_enc #(.MW(MW)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .evt_valid(evt_valid),
    .evt_dx   (evt_dx),
    .evt_dy   (evt_dy),
    .btn_l    (btn_left),
    .btn_m    (btn_mid),
    .btn_r    (btn_right),
    .busy     (busy),
    .push_vld (push_vld),
    .push_dat (push_dat)
  );

  mouse_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (push_vld),
    .push_dat(push_dat),
    .pop     (byte_taken),
    .head    (rx_byte),
    .avail   (rx_avail),
    .fill    (q_fill)
  );

endmodule

// File: rtl/mouse_pkt_chk.sv
module mouse_pkt_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       evt_valid,
  input logic                       busy,
  input logic                       byte_taken,
  input logic                       push_vld,
  input logic                       rx_avail,
  input logic [7:0]                 rx_byte,
  input logic [$clog2(DEPTH+1)-1:0] q_fill
);

  localparam int CW = $clog2(DEPTH + 1);

  logic       rst_d = 1'b0;
  logic [2:0] busy_run;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst)
      busy_run <= '0;
    else if (busy)
      busy_run <= (busy_run == 3'd7) ? busy_run : busy_run + 1'b1;
    else
      busy_run <= '0;
  end

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_state_chk: assert (!rx_avail && rx_byte == 8'h00 && !busy);
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !busy) |=> busy);

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_run == 3'd5) |-> !busy);

  // R7
  fill_limit_chk: assert property (@(posedge clk) disable iff (rst)
    q_fill <= CW'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (q_fill == CW'(DEPTH) && push_vld && !byte_taken) |=> (q_fill == CW'(DEPTH)));

  // R8
  avail_match_chk: assert property (@(posedge clk) disable iff (rst)
    rx_avail == (q_fill != '0));

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && !byte_taken) |=> (rx_avail && $stable(rx_byte)));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_avail |-> (rx_byte == 8'h00));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_avail && byte_taken && !push_vld) |=> !rx_avail);

endmodule

bind mouse_pkt_top mouse_pkt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .busy      (busy),
  .byte_taken(byte_taken),
  .push_vld  (push_vld),
  .rx_avail  (rx_avail),
  .rx_byte   (rx_byte),
  .q_fill    (q_fill)
);

// File: tb/sim_mouse_pkt_top.sv
module sim_mouse_pkt_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_valid = 1'b0;
  logic [9:0] evt_dx = '0;
  logic [9:0] evt_dy = '0;
  logic       btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic       byte_taken = 1'b0;
  logic       busy;
  logic [7:0] rx_byte;
  logic       rx_avail;

  int checks = 0;
  int errors = 0;
  logic [7:0] model[$];

  always #2 clk = ~clk;

  mouse_pkt_top #(.MW(10), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_dx(evt_dx), .evt_dy(evt_dy),
    .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
    .byte_taken(byte_taken), .busy(busy), .rx_byte(rx_byte), .rx_avail(rx_avail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic int sx10(input logic [9:0] v);
    return v[9] ? int'(v) - 1024 : int'(v);
  endfunction

  // offer an event when idle; model the five bytes (dropped once 16 are held)
  task automatic send(input logic [9:0] dx, input logic [9:0] dy,
                      input bit l, input bit m, input bit r);
    logic [7:0] b[5];
    while (busy) @(negedge clk);
    evt_dx = dx; evt_dy = dy; btn_left = l; btn_mid = m; btn_right = r;
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    b[0] = 8'h87 & ~{5'b0, l, m, r};
    b[1] = sat(sx10(dx));
    b[2] = sat(-sx10(dy));
    b[3] = 8'h00;
    b[4] = 8'h00;
    for (int i = 0; i < 5; i++)
      if (model.size() < DEPTH) model.push_back(b[i]);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) begin
      logic [7:0] e;
      e = model.pop_front();
      chk(rx_avail == 1'b1, req, rx_avail, 1);
      chk(rx_byte == e, req, rx_byte, e);
      byte_taken = 1'b1;
      @(negedge clk);
      byte_taken = 1'b0;
    end
    chk(rx_avail == 1'b0, "R8 empty after drain", rx_avail, 0);
  endtask

  task automatic t_reset();
    chk(rx_avail == 1'b0, "R1 rx_avail", rx_avail, 0);
    chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic t_basic();
    int run = 0;
    send(10'd5, 10'd3, 1'b1, 1'b0, 1'b0);
    // one negedge after the accepting edge: nothing written yet
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    chk(rx_avail == 1'b0, "R8 not yet visible", rx_avail, 0);
    @(negedge clk);
    run = 1;
    chk(rx_avail == 1'b1, "R8 visible after first write", rx_avail, 1);
    chk(rx_byte == 8'h83, "R3 left header", rx_byte, 8'h83);
    while (busy) begin
      run++;
      @(negedge clk);
    end
    chk(run == 5, "R2 busy length", run, 5);
    drain("R2 byte order / R5 dy=3");
  endtask

  task automatic t_sat();
    send(10'd300, 10'd300, 1'b0, 1'b1, 1'b1);
    wait_idle();
    chk(rx_byte == 8'h84, "R3 mid+right header", rx_byte, 8'h84);
    drain("R4 R5 positive saturation");
    send(10'h200, 10'h200, 1'b0, 1'b0, 1'b0);
    wait_idle();
    chk(rx_byte == 8'h87, "R3 no buttons", rx_byte, 8'h87);
    drain("R4 R5 negative saturation");
    send(10'd127, 10'h381, 1'b1, 1'b1, 1'b1);
    wait_idle();
    drain("R4 R5 edge values");
  endtask

  task automatic t_busy_ignore();
    send(10'd1, 10'd2, 1'b0, 1'b0, 1'b0);
    evt_dx = 10'd9; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    wait_idle();
    drain("R6 strobe during busy ignored");
  endtask

  task automatic t_empty_pop();
    byte_taken = 1'b1;
    @(negedge clk);
    byte_taken = 1'b0;
    @(negedge clk);
    chk(rx_avail == 1'b0, "R9 pop on empty", rx_avail, 0);
    chk(rx_byte == 8'h00, "R9 empty reads zero", rx_byte, 0);
    send(10'd4, 10'd0, 1'b0, 1'b0, 1'b1);
    wait_idle();
    drain("R9 pop on empty had no effect");
  endtask

  task automatic t_full();
    send(10'd10, 10'd20, 1'b1, 1'b0, 1'b0);
    send(10'd11, 10'd21, 1'b0, 1'b1, 1'b0);
    send(10'd12, 10'd22, 1'b0, 1'b0, 1'b1);
    send(10'd13, 10'd23, 1'b1, 1'b1, 1'b0);
    wait_idle();
    chk(model.size() == DEPTH, "R7 model depth", model.size(), DEPTH);
    drain("R7 R10 full queue, wrapped order");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sat();
    t_busy_ignore();
    t_empty_pop();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule